// File: doc/BRIEF.md
# Privilege-Aware Endian Load/Store Aligner

This block sits between a 32-bit memory data bus and the register file. For a load it takes the bus word, picks the addressed byte or halfword out of it, and returns a 32-bit register value that is zero- or sign-extended. For a store it places the register data on the lanes the access will hit and drives a 4-bit byte-lane enable. The block does not translate addresses and does not raise exceptions. It reports an access that is not naturally aligned through a flag and suppresses every lane for it.

Byte order is chosen per privilege level. A base order is captured from a strap pin while reset is high, and nothing changes it until the next reset. A reverse-order control bit and the current mode come in from the status logic. Kernel accesses always use the base order. User accesses use the opposite order whenever the control bit is set. The status logic can therefore give each process its own byte order, and the choice takes effect on the very next user access with no reset.

Top module: `endian_lane_aligner`

## Requirements
- R1: While `rst` is high on a rising clock edge, `strap_big` is captured as the base order (1 = big-endian, 0 = little-endian). Once reset is released, later changes on `strap_big` do not affect any output.
- R2: When `user_mode` is 0, every access uses the base order, whatever `rev_en` holds.
- R3: When `user_mode` is 1 and `rev_en` is 1, accesses use the order opposite to the base order. When `user_mode` is 1 and `rev_en` is 0, they use the base order. A change on either input alters the outputs in the same cycle.
- R4: Lane i carries bus bits 8i+7:8i. In little-endian order, byte offset a maps to lane a. In big-endian order it maps to lane 3-a. A halfword at offset 0 occupies bits 15:0 in little-endian order and bits 31:16 in big-endian order. A halfword at offset 2 occupies the other half.
- R5: `acc_size` is encoded as 00 = byte, 01 = halfword, 10 = word and 11 = reserved. For an aligned access, `byte_en` has exactly the lanes of that access set. A word access sets all four lanes.
- R6: `st_lanes` holds the store byte replicated into all four lanes for a byte access, and the low store halfword in both halves for a halfword access. A word access passes `st_data` unchanged, and so does the reserved code.
- R7: Byte and halfword loads are zero-extended when `is_signed` is 0 and sign-extended from their top bit when `is_signed` is 1. A word load returns `bus_rdata` unchanged.
- R8: The following accesses set `misalign`, drive `byte_en` to 0000 and return 0 on `ld_result`: a halfword access with `addr_lo[0]` set, a word access with a nonzero `addr_lo`, and any access using the reserved size code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the base order is captured while it is high |
| strap_big | input | 1 | Base byte-order strap, 1 = big-endian |
| rev_en | input | 1 | Reverse-order control bit from the status logic |
| user_mode | input | 1 | 1 = current access runs at user privilege |
| acc_size | input | 2 | Access size: 00 byte, 01 halfword, 10 word, 11 reserved |
| addr_lo | input | 2 | Low two bits of the byte address |
| is_signed | input | 1 | 1 = sign-extend byte and halfword loads |
| st_data | input | 32 | Store data from the register file |
| bus_rdata | input | 32 | Load data from the memory bus |
| byte_en | output | 4 | Byte-lane enables, bit i = lane i |
| st_lanes | output | 32 | Store data steered onto the bus lanes |
| ld_result | output | 32 | Aligned and extended load result |
| misalign | output | 1 | Access is not naturally aligned or uses the reserved size |

## Verification
The block's only internal state is the captured base order. If it held the wrong value, the lane enables and load selection would show mirrored lanes in the first cycle after reset for every byte or halfword access in kernel mode. The bench therefore checks kernel byte accesses straight after each reset and again after toggling the strap. The effective-order logic and the steering logic are combinational, so any error in the mode or reverse-bit handling shows in the same cycle as the access. A model compares all four outputs across every mode, size and offset, for both base orders.

// File: rtl/endian_lane_pkg.sv
package endian_lane_pkg;

    localparam int LANE_W = 8;
    localparam int LANES  = 4;
    localparam int DATA_W = LANE_W * LANES;
    localparam int AW     = $clog2(LANES);
    localparam int NB_W   = AW + 1;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic            eff_big;
        logic            misalign;
        logic [AW-1:0]   low_lane;
        logic [NB_W-1:0] nbytes;
    } lane_plan_t;

    function automatic logic [NB_W-1:0] size_nbytes(input acc_size_e sz);
        case (sz)
            SZ_BYTE: return NB_W'(1);
            SZ_HALF: return NB_W'(2);
            SZ_WORD: return NB_W'(LANES);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/base_order_reg.sv
module base_order_reg (
    input  logic clk,
    input  logic rst,
    input  logic strap_big,
    output logic base_big
);
    always_ff @(posedge clk) begin
        if (rst) begin
            base_big <= strap_big;
        end
    end

    // R1: once out of reset the captured order never moves
    a_r1_base_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(base_big));

endmodule

// File: rtl/lane_locator.sv
module lane_locator
    import endian_lane_pkg::*;
(
    input  logic          base_big,
    input  logic          rev_en,
    input  logic          user_mode,
    input  acc_size_e     size,
    input  logic [AW-1:0] addr_lo,
    output lane_plan_t    plan,
    output logic [LANES-1:0] byte_en
);
    logic [NB_W-1:0] nb;
    int              lo;

    always_comb begin
        nb            = size_nbytes(size);
        plan.nbytes   = nb;
        plan.eff_big  = base_big ^ (rev_en & user_mode);
        if (size == SZ_RSVD) begin
            plan.misalign = 1'b1;
        end else begin
            plan.misalign = (NB_W'(addr_lo) & (nb - NB_W'(1))) != '0;
        end
        if (plan.eff_big) begin
            lo = LANES - int'(nb) - int'(addr_lo);
        end else begin
            lo = int'(addr_lo);
        end
        plan.low_lane = lo[AW-1:0];
        for (int i = 0; i < LANES; i++) begin
            byte_en[i] = !plan.misalign && (i >= lo) && (i < lo + int'(nb));
        end
    end

endmodule

// File: rtl/store_packer.sv
module store_packer
    import endian_lane_pkg::*;
(
    input  logic [NB_W-1:0]   nbytes,
    input  logic [DATA_W-1:0] st_data,
    output logic [DATA_W-1:0] st_lanes
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        int src;
        always_comb begin
            if (nbytes == '0) begin
                src = g;
            end else begin
                src = g % int'(nbytes);
            end
            st_lanes[g*LANE_W +: LANE_W] = st_data[src*LANE_W +: LANE_W];
        end
    end

endmodule

// File: rtl/load_extender.sv
module load_extender
    import endian_lane_pkg::*;
(
    input  lane_plan_t        plan,
    input  logic              is_signed,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] ld_result
);
    logic              sign_bit;
    logic [LANE_W-1:0] fill;
    int                lo;
    int                nb;

    always_comb begin
        ld_result = '0;
        sign_bit  = 1'b0;
        lo        = int'(plan.low_lane);
        nb        = int'(plan.nbytes);
        if (!plan.misalign && nb > 0) begin
            sign_bit = bus_rdata[(lo + nb) * LANE_W - 1];
            fill     = (is_signed && sign_bit) ? '1 : '0;
            for (int i = 0; i < LANES; i++) begin
                if (i < nb) begin
                    ld_result[i*LANE_W +: LANE_W] = bus_rdata[(lo + i)*LANE_W +: LANE_W];
                end else begin
                    ld_result[i*LANE_W +: LANE_W] = fill;
                end
            end
        end else begin
            fill = '0;
        end
    end

endmodule

// File: rtl/endian_lane_aligner.sv
module endian_lane_aligner
    import endian_lane_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        strap_big,
    input  logic        rev_en,
    input  logic        user_mode,
    input  logic [1:0]  acc_size,
    input  logic [1:0]  addr_lo,
    input  logic        is_signed,
    input  logic [31:0] st_data,
    input  logic [31:0] bus_rdata,
    output logic [3:0]  byte_en,
    output logic [31:0] st_lanes,
    output logic [31:0] ld_result,
    output logic        misalign
);
    logic       base_big;
    lane_plan_t plan;
    acc_size_e  size;

    assign size     = acc_size_e'(acc_size);
    assign misalign = plan.misalign;

    base_order_reg u_base (
        .clk       (clk),
        .rst       (rst),
        .strap_big (strap_big),
        .base_big  (base_big)
    );

    lane_locator u_loc (
        .base_big  (base_big),
        .rev_en    (rev_en),
        .user_mode (user_mode),
        .size      (size),
        .addr_lo   (addr_lo),
        .plan      (plan),
        .byte_en   (byte_en)
    );

    store_packer u_st (
        .nbytes   (plan.nbytes),
        .st_data  (st_data),
        .st_lanes (st_lanes)
    );

    load_extender u_ld (
        .plan      (plan),
        .is_signed (is_signed),
        .bus_rdata (bus_rdata),
        .ld_result (ld_result)
    );

    // R2: kernel byte at offset 0 lands where the base order puts it
    a_r2_kernel_base: assert property (@(posedge clk) disable iff (rst)
        (!user_mode && size == SZ_BYTE && addr_lo == 2'd0)
            |-> byte_en == (base_big ? 4'b1000 : 4'b0001));

    // R3: user mode with the reverse bit mirrors the lane
    a_r3_user_reverse: assert property (@(posedge clk) disable iff (rst)
        (user_mode && rev_en && size == SZ_BYTE && addr_lo == 2'd0)
            |-> byte_en == (base_big ? 4'b0001 : 4'b1000));

    // R5: lane count matches the access size
    a_r5_lane_count: assert property (@(posedge clk) disable iff (rst)
        !misalign |-> $countones(byte_en) ==
            ((size == SZ_BYTE) ? 1 : (size == SZ_HALF) ? 2 : 4));

    // R7: unsigned byte loads carry no upper bits
    a_r7_unsigned_byte: assert property (@(posedge clk) disable iff (rst)
        (!misalign && size == SZ_BYTE && !is_signed) |-> ld_result[31:8] == 24'd0);

    // R8: a flagged access touches no lane and returns zero
    a_r8_misalign_quiet: assert property (@(posedge clk) disable iff (rst)
        misalign |-> (byte_en == 4'b0000 && ld_result == 32'd0));

endmodule

// File: tb/endian_lane_aligner_tb.sv
`timescale 1ns/1ps
module endian_lane_aligner_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strap_big = 1'b1;
    logic        rev_en = 1'b0;
    logic        user_mode = 1'b0;
    logic [1:0]  acc_size = 2'b00;
    logic [1:0]  addr_lo = 2'b00;
    logic        is_signed = 1'b0;
    logic [31:0] st_data = '0;
    logic [31:0] bus_rdata = '0;
    logic [3:0]  byte_en;
    logic [31:0] st_lanes;
    logic [31:0] ld_result;
    logic        misalign;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;
    bit  mdl_base;

    always #2 clk = ~clk;

    endian_lane_aligner u_dut (
        .clk(clk), .rst(rst), .strap_big(strap_big), .rev_en(rev_en),
        .user_mode(user_mode), .acc_size(acc_size), .addr_lo(addr_lo),
        .is_signed(is_signed), .st_data(st_data), .bus_rdata(bus_rdata),
        .byte_en(byte_en), .st_lanes(st_lanes), .ld_result(ld_result),
        .misalign(misalign)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference
    task automatic model(output logic [3:0] en, output logic [31:0] so,
                         output logic [31:0] lo, output logic mis);
        bit eb;
        int nb, low;
        logic [31:0] v;
        eb  = mdl_base ^ (rev_en & user_mode);
        nb  = (acc_size == 2'd0) ? 1 : (acc_size == 2'd1) ? 2 : (acc_size == 2'd2) ? 4 : 0;
        mis = (nb == 0) ? 1'b1 : ((int'(addr_lo) % nb) != 0);
        for (int i = 0; i < 4; i++) begin
            int s;
            s = (nb == 0) ? i : (i % nb);
            so[i*8 +: 8] = st_data[s*8 +: 8];
        end
        en = '0;
        lo = '0;
        if (!mis) begin
            low = eb ? (4 - nb - int'(addr_lo)) : int'(addr_lo);
            en  = 4'(((1 << nb) - 1) << low);
            v   = bus_rdata >> (8 * low);
            if (nb == 4) lo = v;
            else if (nb == 2) lo = {{16{is_signed & v[15]}}, v[15:0]};
            else lo = {{24{is_signed & v[7]}}, v[7:0]};
        end
    endtask

    task automatic compare_all();
        logic [3:0] en; logic [31:0] so, lo; logic mis;
        model(en, so, lo, mis);
        check("R5 byte_en", 32'(byte_en), 32'(en));
        check("R6 st_lanes", st_lanes, so);
        check("R7 ld_result", ld_result, lo);
        check("R8 misalign", 32'(misalign), 32'(mis));
    endtask

    task automatic drive(input bit us, input bit rv, input logic [1:0] sz,
                         input logic [1:0] a, input bit sg);
        @(posedge clk); #1;
        user_mode = us; rev_en = rv; acc_size = sz; addr_lo = a; is_signed = sg;
        @(negedge clk);
    endtask

    task automatic do_reset(input bit strap);
        @(posedge clk); #1;
        rst = 1'b1; strap_big = strap;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        mdl_base = strap;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int b = 1; b >= 0; b--) begin
            do_reset(bit'(b));
            st_data = 32'hA1B2_C3D4; bus_rdata = 32'h8172_F304;
            // R1: reset state reflects the strap
            drive(0, 0, 2'b00, 2'b00, 0);
            check("R1 reset base", 32'(byte_en), b ? 32'h8 : 32'h1);
            // R1: strap moves after reset, nothing follows
            #0 strap_big = ~strap_big;
            drive(0, 0, 2'b00, 2'b00, 0);
            check("R1 strap ignored", 32'(byte_en), b ? 32'h8 : 32'h1);
            // R2: kernel ignores the reverse bit
            drive(0, 1, 2'b01, 2'b00, 0);
            check("R2 kernel half", ld_result, b ? 32'h0000_8172 : 32'h0000_F304);
            // R3: user with reverse bit flips immediately
            drive(1, 1, 2'b00, 2'b00, 0);
            check("R3 user reversed", 32'(byte_en), b ? 32'h1 : 32'h8);
            drive(1, 0, 2'b00, 2'b00, 0);
            check("R3 user plain", 32'(byte_en), b ? 32'h8 : 32'h1);
            // R4: byte offset 1 lane
            drive(0, 0, 2'b00, 2'b01, 1);
            check("R4 byte offset1", ld_result, b ? 32'h0000_0072 : 32'hFFFF_FFF3);
            // exhaustive sweep against the model
            for (int p = 0; p < 3; p++) begin
                bus_rdata = (p == 0) ? 32'h8172_F304 : (p == 1) ? 32'h7F80_01FE : 32'hDEAD_5A3C;
                st_data   = (p == 0) ? 32'hA1B2_C3D4 : (p == 1) ? 32'h0102_0304 : 32'hFFEE_8877;
                for (int m = 0; m < 4; m++)
                    for (int s = 0; s < 4; s++)
                        for (int a = 0; a < 4; a++)
                            for (int g = 0; g < 2; g++) begin
                                drive(bit'(m >> 1), bit'(m & 1), 2'(s), 2'(a), bit'(g));
                                compare_all();
                            end
            end
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule